// File: doc/BRIEF.md
# SPI Master with Level-Triggered FIFO Interrupts

This block is a full-duplex SPI master shift engine with a transmit FIFO and a receive FIFO. Each FIFO holds a fixed number of bytes. A bus side pushes words into the transmit FIFO and pops received words from the receive FIFO. The engine starts a word whenever the transmit FIFO holds data. For every word it shifts out, it captures exactly one word from MISO.

The word size can be 8, 16 or 32 bits, so the number of FIFO entries changes with it. With the deep-buffer option turned off, each FIFO holds one entry.

Clock polarity, the transition on which data changes, and the input sample point are each programmable. A 9-bit divisor sets the serial clock rate. Two 2-bit selectors choose the FIFO occupancy condition that raises each interrupt line. An optional hardware slave select stays active as long as the transmit FIFO holds data.

Top module: `spi_lvl_master`

## Requirements
- R1: FIFO capacity in entries is 16/8/4 for wsize codes 0/1/2 (8/16/32 bits, code 3 behaves as 32 bits) when deep_buf=1, and 1 entry when deep_buf=0. A push into a full transmit FIFO is ignored and tx_level does not change.
- R2: While a word is in progress, each SCK level lasts exactly baud+1 clock cycles. A word of N bits makes exactly 2N SCK transitions.
- R3: SCK rests at the cpol level whenever no word is in progress.
- R4: With chg_trail=1, SCK stays at idle for the first half of each bit and data changes on the active-to-idle transition. With chg_trail=0, SCK goes active in the first cycle of a word.
- R5: With smp_end=0, MISO is sampled at the end of the first half of each bit. With smp_end=1, it is sampled at the end of the second half.
- R6: Bits shift MSB first. Each transmitted word yields one received word, right-aligned in rx_data and masked to the word size. Words leave the receive FIFO in arrival order.
- R7: rx_irq follows rx_mode: 0 = FIFO empty; 1 = not empty; 2 = at least half full; 3 = full.
- R8: tx_irq follows tx_mode: 0 = FIFO empty and no word shifting; 1 = FIFO empty; 2 = at least half the slots free; 3 = at least one slot free.
- R9: With hw_ss_en=1, ss_n is low while the transmit FIFO is non-empty. It goes high as soon as the FIFO drains, even if the last word is still shifting. With hw_ss_en=0, ss_n stays high.
- R10: A word that completes while the receive FIFO is full is dropped and sets the sticky rx_ovf flag. A pulse on err_clr clears rx_ovf.
- R11: A pop while the receive FIFO is empty sets the sticky rx_unf flag.
- R12: en=0 empties both FIFOs, aborts any word, returns SCK to idle and holds both interrupt lines low.
- R13: A word starts only when en=1, master_en=1 and the transmit FIFO is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low flushes all state |
| master_en | input | 1 | Allows the engine to start words |
| cpol | input | 1 | Idle level of SCK |
| chg_trail | input | 1 | Data changes on the active-to-idle transition |
| smp_end | input | 1 | Sample MISO at the end of the bit time |
| wsize | input | 2 | Word size code |
| deep_buf | input | 1 | Use full FIFO depth instead of one entry |
| rx_mode | input | 2 | Receive interrupt condition |
| tx_mode | input | 2 | Transmit interrupt condition |
| hw_ss_en | input | 1 | Enables the hardware slave select |
| baud | input | BAUD_W (9) | Half-period divisor minus one |
| tx_push | input | 1 | Push tx_data into the transmit FIFO |
| tx_data | input | 32 | Word to transmit (right-aligned) |
| rx_pop | input | 1 | Pop the receive FIFO head |
| rx_data | output | 32 | Receive FIFO head (right-aligned) |
| err_clr | input | 1 | Clears the sticky flags |
| miso | input | 1 | Serial input |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial output |
| ss_n | output | 1 | Hardware slave select, active low |
| tx_level | output | CW (5) | Transmit FIFO occupancy |
| rx_level | output | CW (5) | Receive FIFO occupancy |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_ovf | output | 1 | Sticky receive overrun |
| rx_unf | output | 1 | Sticky receive underrun (pop when empty) |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The hardest state to reach is a word completing into an already full receive FIFO. In the deep configuration, this needs many words in flight with no pops. The bench reaches it in one-entry mode instead: it sends two words without popping, then checks that the first word is still at the head.

The sample point is also hard to observe, because looping MOSI back to MISO reads the same value at either point. For that test, the bench feeds SCK itself back into MISO. The middle sample then reads the idle level and the end sample reads the active level.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned MAX_W = 32;

  function automatic int unsigned word_bits(input logic [1:0] ws);
    case (ws)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [MAX_W-1:0] word_mask(input logic [1:0] ws);
    return {MAX_W{1'b1}} >> (MAX_W - word_bits(ws));
  endfunction

  function automatic int unsigned fifo_cap(input logic [1:0] ws, input logic deep,
                                           input int unsigned bytes);
    return deep ? bytes / (word_bits(ws) / 8) : 1;
  endfunction

  function automatic logic rx_irq_eval(input logic [1:0] mode, input int unsigned cnt,
                                       input int unsigned cap);
    case (mode)
      2'd0:    return cnt == 0;
      2'd1:    return cnt != 0;
      2'd2:    return 2 * cnt >= cap;
      default: return cnt >= cap;
    endcase
  endfunction

  function automatic logic tx_irq_eval(input logic [1:0] mode, input int unsigned cnt,
                                       input int unsigned cap, input logic busy);
    case (mode)
      2'd0:    return (cnt == 0) && !busy;
      2'd1:    return cnt == 0;
      2'd2:    return 2 * (cap - cnt) >= cap;
      default: return cnt < cap;
    endcase
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = count >= cap;
  assign empty   = count == '0;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  // R1
  fifo_cap_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
    count <= cap);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter import spim_pkg::*; #(
  parameter int unsigned BAUD_W = 9,
  localparam int unsigned HC_W = $clog2(2 * MAX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [1:0]       ws,
  input  logic             cpol,
  input  logic             chg_trail,
  input  logic             smp_end,
  input  logic [BAUD_W-1:0] baud,
  input  logic             tx_avail,
  input  logic [MAX_W-1:0] tx_word,
  input  logic             miso,
  output logic             tx_take,
  output logic             rx_put,
  output logic [MAX_W-1:0] rx_word,
  output logic             busy,
  output logic             sck,
  output logic             mosi
);
  logic [BAUD_W-1:0] dcnt;
  logic [HC_W-1:0]   hcnt;
  logic [MAX_W-1:0]  tsh, rsh, rsh_next;
  logic [HC_W-1:0]   last_half;
  logic              tick, sample_now, word_done;

  assign last_half  = HC_W'(2 * word_bits(ws) - 1);
  assign tick       = busy && (dcnt == baud);
  assign sample_now = tick && (hcnt[0] == smp_end);
  assign word_done  = tick && (hcnt == last_half);
  assign rsh_next   = sample_now ? {rsh[MAX_W-2:0], miso} : rsh;
  assign rx_word    = rsh_next & word_mask(ws);
  assign rx_put     = word_done;
  assign tx_take    = !busy && run && tx_avail;
  assign sck        = busy ? (cpol ^ (hcnt[0] ^ ~chg_trail)) : cpol;
  assign mosi       = busy && tsh[MAX_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; dcnt <= '0; hcnt <= '0; tsh <= '0; rsh <= '0;
    end else if (clear) begin
      busy <= 1'b0; dcnt <= '0; hcnt <= '0; tsh <= '0; rsh <= '0;
    end else if (tx_take) begin
      busy <= 1'b1;
      dcnt <= '0;
      hcnt <= '0;
      rsh  <= '0;
      tsh  <= (tx_word & word_mask(ws)) << (MAX_W - word_bits(ws));
    end else if (busy) begin
      rsh <= rsh_next;
      if (tick) begin
        dcnt <= '0;
        if (word_done) busy <= 1'b0;
        else           hcnt <= hcnt + 1'b1;
        if (hcnt[0]) tsh <= tsh << 1;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_lvl_master.sv
module spi_lvl_master import spim_pkg::*; #(
  parameter int unsigned FIFO_BYTES = 16,
  parameter int unsigned BAUD_W = 9,
  localparam int unsigned CW = $clog2(FIFO_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              master_en,
  input  logic              cpol,
  input  logic              chg_trail,
  input  logic              smp_end,
  input  logic [1:0]        wsize,
  input  logic              deep_buf,
  input  logic [1:0]        rx_mode,
  input  logic [1:0]        tx_mode,
  input  logic              hw_ss_en,
  input  logic [BAUD_W-1:0] baud,
  input  logic              tx_push,
  input  logic [31:0]       tx_data,
  input  logic              rx_pop,
  output logic [31:0]       rx_data,
  input  logic              err_clr,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic [CW-1:0]     tx_level,
  output logic [CW-1:0]     rx_level,
  output logic              rx_empty,
  output logic              rx_ovf,
  output logic              rx_unf,
  output logic              rx_irq,
  output logic              tx_irq
);
  logic [CW-1:0] cap;
  logic [31:0]   tx_head, rx_word;
  logic          tx_full, tx_empty, rx_full;
  logic          tx_take, rx_put, busy;

  assign cap = CW'(fifo_cap(wsize, deep_buf, FIFO_BYTES));

  spim_fifo #(.DEPTH(FIFO_BYTES), .W(MAX_W)) u_txq (
    .clk, .rst_n, .flush(!en), .cap,
    .push(tx_push && en), .din(tx_data), .pop(tx_take),
    .dout(tx_head), .count(tx_level), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.DEPTH(FIFO_BYTES), .W(MAX_W)) u_rxq (
    .clk, .rst_n, .flush(!en), .cap,
    .push(rx_put), .din(rx_word), .pop(rx_pop && en),
    .dout(rx_data), .count(rx_level), .full(rx_full), .empty(rx_empty));

  spim_shifter #(.BAUD_W(BAUD_W)) u_eng (
    .clk, .rst_n, .run(en && master_en), .clear(!en),
    .ws(wsize), .cpol, .chg_trail, .smp_end, .baud,
    .tx_avail(!tx_empty), .tx_word(tx_head), .miso,
    .tx_take, .rx_put, .rx_word, .busy, .sck, .mosi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ovf <= 1'b0; rx_unf <= 1'b0;
    end else if (!en || err_clr) begin
      rx_ovf <= 1'b0; rx_unf <= 1'b0;
    end else begin
      if (rx_put && rx_full)   rx_ovf <= 1'b1;
      if (rx_pop && rx_empty)  rx_unf <= 1'b1;
    end
  end

  assign ss_n   = !(hw_ss_en && en && !tx_empty);
  assign rx_irq = en && rx_irq_eval(rx_mode, int'(rx_level), int'(cap));
  assign tx_irq = en && tx_irq_eval(tx_mode, int'(tx_level), int'(cap), busy);

  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !$past(rx_ovf)) |-> $past(rx_put && rx_full && en));
  // R11
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_unf && !$past(rx_unf)) |-> $past(rx_pop && rx_empty && en));
  // R12
  disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_level == '0 && rx_level == '0 && !busy));
  // R13
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> (en && master_en && tx_level != '0));
endmodule

// File: tb/tb_spi_lvl_master.sv
module tb_spi_lvl_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic en = 0, master_en = 0, cpol = 0, chg_trail = 1, smp_end = 0, deep_buf = 1;
  logic [1:0] wsize = 0, rx_mode = 0, tx_mode = 0;
  logic hw_ss_en = 0, tx_push = 0, rx_pop = 0, err_clr = 0, loopback = 1;
  logic [8:0] baud = 0;
  logic [31:0] tx_data = 0, rx_data;
  logic sck, mosi, ss_n, rx_empty, rx_ovf, rx_unf, rx_irq, tx_irq, miso;
  logic [4:0] tx_level, rx_level;

  assign miso = loopback ? mosi : sck;

  spi_lvl_master dut (.*);

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); tx_push = 1; tx_data = d;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop();
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic wait_rx(input int n, input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (int'(rx_level) >= n) break;
    end
  endtask

  function automatic logic [31:0] msk(input logic [1:0] ws);
    case (ws)
      2'd0: return 32'h0000_00FF;
      2'd1: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  typedef struct packed {
    logic [1:0] ws; logic cp; logic chg; logic smp; logic [8:0] b; logic [31:0] d;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b0, 1'b1, 1'b0, 9'd0, 32'h1234_56A5},
    '{2'd1, 1'b1, 1'b1, 1'b1, 9'd1, 32'hFFFF_1234},
    '{2'd2, 1'b0, 1'b0, 1'b0, 9'd2, 32'hDEAD_BEEF},
    '{2'd0, 1'b1, 1'b0, 1'b1, 9'd3, 32'h0000_003C},
    '{2'd1, 1'b0, 1'b0, 1'b1, 9'd0, 32'h0000_8001},
    '{2'd2, 1'b1, 1'b1, 1'b0, 9'd1, 32'h8000_0001}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset / disabled state
    chk(tx_level == 0 && rx_level == 0, "R12 reset levels", {tx_level, rx_level}, 0);
    chk(sck == 0 && ss_n == 1, "R3 reset sck/ss", {sck, ss_n}, 32'h1);
    chk(rx_irq == 0 && tx_irq == 0, "R12 irq low when disabled", {rx_irq, tx_irq}, 0);

    // Vector table: loopback words across modes (R2 R3 R4 R6)
    foreach (VECS[k]) begin
      automatic vec_t v = VECS[k];
      automatic int nb = (v.ws == 0) ? 8 : (v.ws == 1) ? 16 : 32;
      automatic int trans = 0, runlen = 1, bad = 0;
      automatic bit run_valid;
      automatic logic prev;
      @(negedge clk);
      en = 1; master_en = 1; deep_buf = 1; loopback = 1;
      wsize = v.ws; cpol = v.cp; chg_trail = v.chg; smp_end = v.smp; baud = v.b;
      @(negedge clk);
      chk(sck == v.cp, "R3 idle level", sck, v.cp);
      push(v.d);
      @(negedge clk);
      chk(sck == (v.cp ^ !v.chg), "R4 first half level", sck, v.cp ^ !v.chg);
      run_valid = (sck != v.cp);
      trans = run_valid ? 1 : 0;
      prev = sck;
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk);
        if (sck != prev) begin
          trans++;
          if (run_valid && runlen != int'(v.b) + 1) bad++;
          run_valid = 1; runlen = 1; prev = sck;
        end else runlen++;
        if (rx_level != 0) break;
      end
      chk(bad == 0, "R2 half-period length", bad, 0);
      chk(trans == 2 * nb, "R2 transitions per word", trans, 2 * nb);
      chk(rx_data == (v.d & msk(v.ws)), "R6 loopback word", rx_data, v.d & msk(v.ws));
      pop();
    end

    // R5 sample point with MISO = SCK
    loopback = 0; wsize = 0; cpol = 0; chg_trail = 1; baud = 0;
    smp_end = 0;
    push(32'h55); wait_rx(1, 200);
    chk(rx_data == 32'h00, "R5 middle sample", rx_data, 32'h00);
    pop();
    smp_end = 1;
    push(32'h55); wait_rx(1, 200);
    chk(rx_data == 32'hFF, "R5 end sample", rx_data, 32'hFF);
    pop();
    loopback = 1; smp_end = 0;

    // R9 / R13 hardware select and start gating
    master_en = 0; hw_ss_en = 1; baud = 3;
    @(negedge clk);
    chk(ss_n == 1, "R9 released when empty", ss_n, 1);
    push(32'hA1);
    repeat (100) @(negedge clk);
    chk(tx_level == 1 && rx_level == 0, "R13 no start without master", {tx_level, rx_level}, 32'h20);
    chk(ss_n == 0, "R9 asserted with data", ss_n, 0);
    hw_ss_en = 0; @(negedge clk);
    chk(ss_n == 1, "R9 disabled select", ss_n, 1);
    hw_ss_en = 1; master_en = 1;
    @(negedge clk); @(negedge clk);
    chk(ss_n == 1 && tx_level == 0 && rx_level == 0, "R9 released at drain mid-word",
        {ss_n, tx_level, rx_level}, 32'h400);
    wait_rx(1, 200);
    chk(rx_data == 32'hA1, "R6 word after gating", rx_data, 32'hA1);
    pop(); hw_ss_en = 0;

    // R7 receive interrupt thresholds (32-bit, cap 4)
    wsize = 2; baud = 0;
    for (int i = 1; i <= 4; i++) push(i);
    wait_rx(4, 1000);
    rx_mode = 3; @(negedge clk);
    chk(rx_irq == 1, "R7 full", rx_irq, 1);
    rx_mode = 2; @(negedge clk);
    chk(rx_irq == 1, "R7 half full", rx_irq, 1);
    chk(rx_data == 1, "R6 order", rx_data, 1);
    pop(); pop(); pop();
    chk(rx_irq == 0, "R7 below half", rx_irq, 0);
    rx_mode = 1; @(negedge clk);
    chk(rx_irq == 1, "R7 not empty", rx_irq, 1);
    rx_mode = 0; @(negedge clk);
    chk(rx_irq == 0, "R7 empty code with data", rx_irq, 0);
    pop();
    chk(rx_irq == 1, "R7 empty", rx_irq, 1);

    // R10 / R11 overrun and underrun in one-entry mode
    deep_buf = 0; wsize = 0;
    push(32'h11); wait_rx(1, 200);
    push(32'h22);
    repeat (40) @(negedge clk);
    chk(rx_ovf == 1, "R10 overrun set", rx_ovf, 1);
    chk(rx_data == 32'h11 && rx_level == 1, "R10 word dropped", rx_data, 32'h11);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    chk(rx_ovf == 0, "R10 cleared", rx_ovf, 0);
    pop();
    chk(rx_unf == 0, "R11 no underrun yet", rx_unf, 0);
    pop();
    chk(rx_unf == 1, "R11 underrun set", rx_unf, 1);

    // R8 / R1 transmit interrupt thresholds (16-bit, cap 8), engine stopped
    master_en = 0; deep_buf = 1; wsize = 1;
    tx_mode = 0; @(negedge clk);
    chk(tx_irq == 1, "R8 all empty", tx_irq, 1);
    for (int i = 0; i < 4; i++) push(i);
    tx_mode = 2; @(negedge clk);
    chk(tx_irq == 1, "R8 half empty", tx_irq, 1);
    tx_mode = 1; @(negedge clk);
    chk(tx_irq == 0, "R8 empty code with data", tx_irq, 0);
    push(32'h5);
    tx_mode = 2; @(negedge clk);
    chk(tx_irq == 0, "R8 less than half free", tx_irq, 0);
    tx_mode = 3; @(negedge clk);
    chk(tx_irq == 1, "R8 slot free", tx_irq, 1);
    for (int i = 0; i < 3; i++) push(i);
    chk(tx_level == 8, "R1 16-bit capacity", tx_level, 8);
    chk(tx_irq == 0, "R8 full", tx_irq, 0);
    push(32'h9);
    chk(tx_level == 8, "R1 push to full ignored", tx_level, 8);

    // R12 disable flushes
    rx_mode = 0; cpol = 1; en = 0;
    @(negedge clk);
    chk(tx_level == 0 && rx_level == 0, "R12 flush", {tx_level, rx_level}, 0);
    chk(sck == 1, "R12 sck idle", sck, 1);
    chk(rx_irq == 0 && tx_irq == 0, "R12 irq held low", {rx_irq, tx_irq}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule